// File: doc/BRIEF.md
# Host Data FIFO with Command Capture

This block sits behind the data register of a storage controller and holds the bytes that pass between the host and the controller's transfer logic. A mode input selects where host writes go. In command-capture mode each write is appended to a command buffer, and that buffer's contents and length are exposed to the command logic. In normal mode writes go into a transfer buffer. That buffer has separate read and write pointers and a signed count of pending bytes. Host reads pop the transfer buffer only while the phase input shows a programmed-I/O input phase.

Control logic can load a two-byte status response (status byte, then zero) in one cycle. It can also issue a flush, which raises the function-complete flag, pulses a sequence-step clear and zeroes the flags register without discarding stored bytes. The FIFO-flags register follows the buffer occupancy after every host push or pop.

The block never stalls the host. Every strobe is taken in the cycle it is presented, so there is no back-pressure. A write that finds no room is dropped and marked by a one-cycle overrun pulse.

Top module: `hba_data_fifo`

## Requirements
- R1: After reset, pending, fifo_flags, cmd_len, rd_data, fc_flag, seq_clr and overrun are all zero.
- R2: A normal-mode write (cmd_mode=0) stores wr_data, raises pending by one, and leaves fifo_flags equal to the number of stored bytes not yet read.
- R3: A normal-mode write is dropped, with overrun high for one cycle and pending unchanged, whenever the write pointer is at DEPTH-1. This also holds after reads if the buffer has not drained. From empty, at most DEPTH-1 bytes are accepted.
- R4: A read (rd_en) with phase nonzero and bytes pending returns the oldest byte on rd_data in the next cycle, pulses rd_valid and lowers pending by one.
- R5: When a read empties the buffer, both pointers return to zero, so DEPTH-1 further writes are accepted without overrun.
- R6: A read with phase equal to 3'b000 returns 8'h00 on rd_data and pops nothing.
- R7: A read with phase nonzero on an empty buffer keeps the previous rd_data value and leaves pending and fifo_flags at zero.
- R8: In command-capture mode (cmd_mode=1), a write appends wr_data to cmd_bytes at byte lane cmd_len (bits 8*cmd_len+7 down to 8*cmd_len) while cmd_len < CMD_DEPTH. Once full, the write is dropped with overrun pulsed. These writes leave the transfer buffer unchanged. cmd_clear returns cmd_len to zero.
- R9: flush sets fc_flag (held until intr_ack), pulses seq_clr for one cycle and zeroes fifo_flags, while pending and the stored bytes stay unchanged.
- R10: status_load discards the transfer buffer and replaces it with status_byte followed by 8'h00, with pending and fifo_flags set to 2. It takes priority over a read, a write and a flush in the same cycle.
- R11: When rd_en and a normal-mode write arrive in the same cycle, the read is served and the write is dropped without an overrun pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_mode | input | 1 | 1: host writes go to the command buffer |
| phase | input | 3 | Bus phase bits; zero means no programmed-I/O input |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe for the data register |
| flush | input | 1 | Flush command strobe |
| status_load | input | 1 | Load a two-byte status response |
| status_byte | input | 8 | Status byte for the response |
| cmd_clear | input | 1 | Empty the command buffer |
| intr_ack | input | 1 | Clears fc_flag |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | High the cycle after a read strobe |
| pending | output | DEPTH_BITS+2 (signed) | Pending transfer byte count |
| fifo_flags | output | DEPTH_BITS | FIFO-flags register |
| overrun | output | 1 | One-cycle pulse for a dropped write |
| fc_flag | output | 1 | Function-complete interrupt flag |
| seq_clr | output | 1 | One-cycle sequence-step clear pulse |
| cmd_len | output | CMD_LEN_BITS | Bytes held in the command buffer |
| cmd_bytes | output | 8*CMD_DEPTH | Command buffer contents, byte 0 in the low lane |

## Verification
The table walk interleaves pushes, pops and command-mode writes. This separates in-order popping from a stack or from stale reads, and shows that command bytes never leak into the transfer count. A fill past capacity, followed by one pop and another write, tells a pointer-based overrun apart from a count-based one. A full drain and refill shows the pointers rewinding. Zero-phase reads, empty reads, flush on a full buffer, status load over live data and a colliding read with a write each isolate one priority or masking rule.

// File: rtl/hba_fifo_pkg.sv
package hba_fifo_pkg;
  // operation applied to the transfer buffer in a cycle
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_PUSH = 2'd1,
    XF_POP  = 2'd2,
    XF_LOAD = 2'd3
  } xfer_op_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/hba_xfer_buf.sv
module hba_xfer_buf
  import hba_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PEND_W = PTR_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  xfer_op_e                 op,
  input  logic                     pio_in,
  input  logic [BYTE_W-1:0]        push_byte,
  input  logic [BYTE_W-1:0]        stat_byte,
  output logic [BYTE_W-1:0]        rd_byte,
  output logic signed [PEND_W-1:0] pend,
  output logic [PTR_W-1:0]         occ_next,
  output logic                     drop
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr, wptr_d, rptr_d;
  logic signed [PEND_W-1:0] pend_d;
  logic [BYTE_W-1:0] rd_d;
  logic              drop_d, store;

  always_comb begin
    wptr_d = wptr;
    rptr_d = rptr;
    pend_d = pend;
    rd_d   = rd_byte;
    drop_d = 1'b0;
    store  = 1'b0;
    unique case (op)
      XF_LOAD: begin
        rptr_d = '0;
        wptr_d = PTR_W'(2);
        pend_d = PEND_W'(2);
      end
      XF_POP: begin
        if (!pio_in) begin
          rd_d = '0;
        end else if (rptr < wptr) begin
          rd_d   = mem[rptr];
          pend_d = pend - PEND_W'(1);
          if (rptr + PTR_W'(1) == wptr) begin
            rptr_d = '0;
            wptr_d = '0;
          end else begin
            rptr_d = rptr + PTR_W'(1);
          end
        end
      end
      XF_PUSH: begin
        if (wptr == PTR_W'(DEPTH - 1)) begin
          drop_d = 1'b1;
        end else begin
          store  = 1'b1;
          wptr_d = wptr + PTR_W'(1);
          pend_d = pend + PEND_W'(1);
        end
      end
      default: ;
    endcase
    occ_next = wptr_d - rptr_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      pend    <= '0;
      rd_byte <= '0;
      drop    <= 1'b0;
    end else begin
      wptr    <= wptr_d;
      rptr    <= rptr_d;
      pend    <= pend_d;
      rd_byte <= rd_d;
      drop    <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (op == XF_LOAD) begin
      mem[0] <= stat_byte;
      mem[1] <= '0;
    end else if (store) begin
      mem[wptr] <= push_byte;
    end
  end
endmodule

// File: rtl/hba_cmd_capture.sv
module hba_cmd_capture
  import hba_fifo_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  localparam int IDX_W = $clog2(CMD_DEPTH),
  localparam int LEN_W = $clog2(CMD_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic                        clr,
  input  logic [BYTE_W-1:0]           din,
  output logic [LEN_W-1:0]            len,
  output logic [BYTE_W*CMD_DEPTH-1:0] flat,
  output logic                        drop
);
  logic [BYTE_W-1:0] mem [CMD_DEPTH];
  logic              room;

  assign room = (len < LEN_W'(CMD_DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len  <= '0;
      drop <= 1'b0;
      for (int i = 0; i < CMD_DEPTH; i++) mem[i] <= '0;
    end else begin
      drop <= 1'b0;
      if (clr) begin
        len <= '0;
      end else if (wr) begin
        if (room) begin
          mem[len[IDX_W-1:0]] <= din;
          len <= len + LEN_W'(1);
        end else begin
          drop <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_lane
    assign flat[g*BYTE_W +: BYTE_W] = mem[g];
  end
endmodule

// File: rtl/hba_data_fifo.sv
module hba_data_fifo
  import hba_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PEND_W = PTR_W + 2,
  localparam int LEN_W = $clog2(CMD_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_mode,
  input  logic [2:0]                  phase,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_data,
  input  logic                        rd_en,
  input  logic                        flush,
  input  logic                        status_load,
  input  logic [7:0]                  status_byte,
  input  logic                        cmd_clear,
  input  logic                        intr_ack,
  output logic [7:0]                  rd_data,
  output logic                        rd_valid,
  output logic signed [PEND_W-1:0]    pending,
  output logic [PTR_W-1:0]            fifo_flags,
  output logic                        overrun,
  output logic                        fc_flag,
  output logic                        seq_clr,
  output logic [LEN_W-1:0]            cmd_len,
  output logic [8*CMD_DEPTH-1:0]      cmd_bytes
);
  xfer_op_e         xop;
  logic [PTR_W-1:0] occ_next;
  logic             xdrop, cdrop, cwr, host_touch;

  always_comb begin
    if (status_load)              xop = XF_LOAD;
    else if (rd_en)               xop = XF_POP;
    else if (wr_en && !cmd_mode)  xop = XF_PUSH;
    else                          xop = XF_IDLE;
  end

  assign cwr        = wr_en && cmd_mode;
  assign host_touch = (xop == XF_POP) || (xop == XF_PUSH);

  hba_xfer_buf #(.DEPTH(DEPTH)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (xop),
    .pio_in    (phase != 3'b000),
    .push_byte (wr_data),
    .stat_byte (status_byte),
    .rd_byte   (rd_data),
    .pend      (pending),
    .occ_next  (occ_next),
    .drop      (xdrop)
  );

  hba_cmd_capture #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cwr),
    .clr   (cmd_clear),
    .din   (wr_data),
    .len   (cmd_len),
    .flat  (cmd_bytes),
    .drop  (cdrop)
  );

  assign overrun = xdrop | cdrop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_flags <= '0;
      fc_flag    <= 1'b0;
      seq_clr    <= 1'b0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      seq_clr  <= flush;
      if (status_load)     fifo_flags <= PTR_W'(2);
      else if (flush)      fifo_flags <= '0;
      else if (host_touch) fifo_flags <= occ_next;
      if (flush)           fc_flag <= 1'b1;
      else if (intr_ack)   fc_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hba_data_fifo_chk.sv
module hba_data_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PEND_W = PTR_W + 2,
  localparam int LEN_W = $clog2(CMD_DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_mode,
  input logic [2:0]               phase,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     flush,
  input logic                     status_load,
  input logic                     cmd_clear,
  input logic [7:0]               rd_data,
  input logic                     rd_valid,
  input logic signed [PEND_W-1:0] pending,
  input logic [PTR_W-1:0]         fifo_flags,
  input logic                     overrun,
  input logic                     fc_flag,
  input logic                     seq_clr,
  input logic [LEN_W-1:0]         cmd_len
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cmd_mode && !rd_en && !status_load && pending == PEND_W'(DEPTH - 1))
      |=> (overrun && $stable(pending)));

  a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !status_load && phase != 3'b000 && pending > 0)
      |=> (rd_valid && pending == $past(pending) - 1));

  a_r6_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !status_load && phase == 3'b000)
      |=> (rd_data == 8'h00 && $stable(pending)));

  a_r8_cmd_append: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_mode && !cmd_clear && cmd_len < LEN_W'(CMD_DEPTH))
      |=> (cmd_len == $past(cmd_len) + 1'b1));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !status_load) |=> (fc_flag && seq_clr && fifo_flags == '0));

  a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
    status_load |=> (pending == 2 && fifo_flags == PTR_W'(2)));
endmodule

bind hba_data_fifo hba_data_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (.*);

// File: tb/hba_data_fifo_tb.sv
module hba_data_fifo_tb;
  localparam int DEPTH = 16;
  localparam int CMD_DEPTH = 16;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int PEND_W = PTR_W + 2;
  localparam int LEN_W = $clog2(CMD_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0;
  logic status_load = 1'b0, cmd_clear = 1'b0, intr_ack = 1'b0;
  logic [2:0] phase = 3'd0;
  logic [7:0] wr_data = 8'h00, status_byte = 8'h00;
  logic [7:0] rd_data;
  logic rd_valid, overrun, fc_flag, seq_clr;
  logic signed [PEND_W-1:0] pending;
  logic [PTR_W-1:0] fifo_flags;
  logic [LEN_W-1:0] cmd_len;
  logic [8*CMD_DEPTH-1:0] cmd_bytes;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hba_data_fifo #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_dut (.*);

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
    end
  endtask

  // drive one host access at a negedge, return at the next negedge
  task automatic host(bit w, bit r, bit cm, logic [2:0] ph, logic [7:0] d);
    wr_en = w; rd_en = r; cmd_mode = cm; phase = ph; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // {op[1:0], byte[7:0], flags[3:0], cmd_len[4:0]}; op 0 push, 1 pop, 2 cmd write
  localparam logic [18:0] VEC [10] = '{
    {2'd0, 8'hA1, 4'd1, 5'd0},
    {2'd0, 8'hB2, 4'd2, 5'd0},
    {2'd1, 8'hA1, 4'd1, 5'd0},
    {2'd0, 8'hC3, 4'd2, 5'd0},
    {2'd1, 8'hB2, 4'd1, 5'd0},
    {2'd1, 8'hC3, 4'd0, 5'd0},
    {2'd2, 8'h11, 4'd0, 5'd1},
    {2'd2, 8'h22, 4'd0, 5'd2},
    {2'd0, 8'h5A, 4'd1, 5'd2},
    {2'd1, 8'h5A, 4'd0, 5'd2}
  };

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pending", int'(pending), 0);
    check("R1 flags", int'(fifo_flags), 0);
    check("R1 cmd_len", int'(cmd_len), 0);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 fc_flag", int'(fc_flag), 0);
    check("R1 seq_clr/overrun", int'({seq_clr, overrun}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 push, R4 pop order, R8 command capture
    for (int i = 0; i < 10; i++) begin
      logic [1:0] op;
      logic [7:0] b;
      op = VEC[i][18:17];
      b  = VEC[i][16:9];
      host(op == 2'd0 || op == 2'd2, op == 2'd1, op == 2'd2, 3'd1, b);
      if (op == 2'd1) begin
        check("R4 pop byte", int'(rd_data), int'(b));
        check("R4 rd_valid", int'(rd_valid), 1);
      end
      check("R2 flags", int'(fifo_flags), int'(VEC[i][8:5]));
      check("R2 pending", int'(pending), int'(VEC[i][8:5]));
      check("R8 cmd_len", int'(cmd_len), int'(VEC[i][4:0]));
    end
    check("R8 lane0", int'(cmd_bytes[7:0]), 8'h11);
    check("R8 lane1", int'(cmd_bytes[15:8]), 8'h22);

    // R6 zero phase read
    host(1, 0, 0, 3'd1, 8'h77);
    host(0, 1, 0, 3'd0, 8'h00);
    check("R6 zero data", int'(rd_data), 0);
    check("R6 no pop", int'(pending), 1);
    host(0, 1, 0, 3'd1, 8'h00);
    check("R6 byte kept", int'(rd_data), 8'h77);
    // R7 empty read
    host(0, 1, 0, 3'd2, 8'h00);
    check("R7 stale data", int'(rd_data), 8'h77);
    check("R7 pending", int'(pending), 0);
    check("R7 flags", int'(fifo_flags), 0);

    // R3 fill beyond capacity
    for (int i = 0; i < DEPTH - 1; i++) begin
      host(1, 0, 0, 3'd1, 8'h10 + 8'(i));
      check("R3 accepted", int'(overrun), 0);
    end
    host(1, 0, 0, 3'd1, 8'hEE);
    check("R3 overrun", int'(overrun), 1);
    check("R3 pending max", int'(pending), DEPTH - 1);
    host(0, 1, 0, 3'd1, 8'h00);
    check("R3 first out", int'(rd_data), 8'h10);
    host(1, 0, 0, 3'd1, 8'hEF);
    check("R3 pointer overrun", int'(overrun), 1);
    check("R3 pending after", int'(pending), DEPTH - 2);
    // R5 drain and refill
    for (int i = 1; i < DEPTH - 1; i++) host(0, 1, 0, 3'd1, 8'h00);
    check("R5 last out", int'(rd_data), 8'h10 + DEPTH - 2);
    check("R5 drained", int'(pending), 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      host(1, 0, 0, 3'd1, 8'h40 + 8'(i));
      check("R5 refill", int'(overrun), 0);
    end
    check("R5 flags full", int'(fifo_flags), DEPTH - 1);

    // R9 flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R9 fc_flag", int'(fc_flag), 1);
    check("R9 seq_clr", int'(seq_clr), 1);
    check("R9 flags", int'(fifo_flags), 0);
    check("R9 pending kept", int'(pending), DEPTH - 1);
    @(negedge clk);
    check("R9 seq pulse", int'(seq_clr), 0);
    check("R9 fc held", int'(fc_flag), 1);
    intr_ack = 1'b1;
    @(negedge clk);
    intr_ack = 1'b0;
    check("R9 ack", int'(fc_flag), 0);

    // R10 status load over live data, colliding with a read
    status_load = 1'b1; status_byte = 8'h42; rd_en = 1'b1; phase = 3'd1;
    @(negedge clk);
    status_load = 1'b0; rd_en = 1'b0;
    check("R10 pending", int'(pending), 2);
    check("R10 flags", int'(fifo_flags), 2);
    host(0, 1, 0, 3'd1, 8'h00);
    check("R10 status byte", int'(rd_data), 8'h42);
    host(0, 1, 0, 3'd1, 8'h00);
    check("R10 zero byte", int'(rd_data), 0);
    check("R10 drained", int'(pending), 0);

    // R11 read and write together
    host(1, 0, 0, 3'd1, 8'h09);
    host(1, 1, 0, 3'd1, 8'h33);
    check("R11 read wins", int'(rd_data), 8'h09);
    check("R11 no overrun", int'(overrun), 0);
    check("R11 write dropped", int'(pending), 0);

    // R8 command overrun and clear
    cmd_clear = 1'b1;
    @(negedge clk);
    cmd_clear = 1'b0;
    check("R8 cleared", int'(cmd_len), 0);
    for (int i = 0; i < CMD_DEPTH; i++) host(1, 0, 1, 3'd1, 8'h80 + 8'(i));
    check("R8 cmd full", int'(cmd_len), CMD_DEPTH);
    check("R8 last lane", int'(cmd_bytes[8*CMD_DEPTH-1 -: 8]), 8'h80 + CMD_DEPTH - 1);
    host(1, 0, 1, 3'd1, 8'hFF);
    check("R8 cmd overrun", int'(overrun), 1);
    check("R8 len held", int'(cmd_len), CMD_DEPTH);
    check("R8 xfer untouched", int'(pending), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule